// File: doc/BRIEF.md
# Vertex Record Size Calculator

This block works out how many bytes one raw vertex record occupies in a graphics command stream. It also works out where each attribute starts inside that record. The shape of a record comes from two sources. The first is a pair of descriptor words that give the encoding of every attribute: absent, direct, or referenced through an 8-bit or 16-bit index. The second is one of eight format entries, each made of three words, that give component counts and component formats. Both sources are loaded through a simple register-write port.

A request names one format entry. One clock edge later, the block presents two results: the record size, and a vector of 21 byte offsets, one per attribute in stream order. Both results hold until the next request.

The block does only the arithmetic. It fetches no array data, dequantises no values and converts no formats.

Top module: `vrs_record_size`

## Requirements
- R1: While reset is low, the block clears `rsp_valid`, `rsp_size`, `rsp_offsets`, both descriptor words and every format word.
- R2: `rsp_valid` is high exactly in the cycle after a cycle with `req_valid` high. `rsp_size` and `rsp_offsets` take new values only on such a request, and configuration writes alone leave them unchanged.
- R3: Bits 0 to 8 of the low descriptor word mark the nine matrix-index attributes present. Each present matrix-index attribute adds 1 byte.
- R4: Attribute types are 2-bit fields. Position, normal, colour 0 and colour 1 use low-descriptor bits [10:9], [12:11], [14:13] and [16:15]. Texture coordinate k uses high-descriptor bits [2k+1:2k]. Type 0 adds 0 bytes, 1 is direct, 2 adds 1 byte per index and 3 adds 2 bytes per index.
- R5: A direct attribute's size is its component count times its component size. Component codes 0 and 1 take 1 byte, codes 2 and 3 take 2 bytes, and codes 4 to 7 take 4 bytes. The position count bit selects 2 or 3 components, the normal count bit 3 or 9, and the texture count bit 1 or 2.
- R6: A direct colour's size depends only on its format code: codes 0 and 3 give 2 bytes, codes 1 and 4 give 3 bytes, and codes 2 and 5 to 7 give 4 bytes. The colour count bit has no effect.
- R7: An indexed normal takes three indices only when its count bit selects nine components and bit 31 of format word A is set. Otherwise it takes one index.
- R8: Count bit and format code (count bit first, format code in the next 3 bits) sit as follows:
  - Word A: position at bit 0, normal at 9, colour 0 at 13, colour 1 at 17, texture 0 at 21.
  - Word B: texture 1 at 0, texture 2 at 9, texture 3 at 18, texture 4 at 27.
  - Word C: texture 5 at 5, texture 6 at 14, texture 7 at 23.
- R9: A write goes to the register chosen by address bits [7:4]: 5 is the low descriptor, 6 the high descriptor, and 7, 8 and 9 are format words A, B and C of the entry chosen by address bits [2:0]. Writes to any other group change nothing, and each entry keeps its own words.
- R10: The offset of attribute i sits in `rsp_offsets[i*8 +: 8]` and equals the sum of the sizes of attributes 0 to i-1. The stream order is:
  - 0: position/normal matrix index.
  - 1 to 8: texture matrix indices 0 to 7.
  - 9: position.
  - 10: normal.
  - 11: colour 0.
  - 12: colour 1.
  - 13 to 20: texture coordinates 0 to 7.
  `rsp_size` is the sum of all 21 sizes, so a record with every attribute absent has size 0.
- R11: The largest possible record, 129 bytes, fits in `rsp_size` without wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_addr | input | ADDR_W (8) | Register address: group in [7:4], entry in [2:0] |
| cfg_wr_data | input | 32 | Write data |
| req_valid | input | 1 | Compute request |
| req_fmt | input | IDX_W (3) | Format entry used by the request |
| rsp_valid | output | 1 | Result presented this cycle |
| rsp_size | output | SIZE_W (8) | Record length in bytes |
| rsp_offsets | output | 21*SIZE_W (168) | Per-attribute start offsets, attribute i at bits [i*SIZE_W +: SIZE_W] |

## Verification
The bench builds the block with its default values: eight format entries, an 8-bit address and 8-bit size and offset fields. With eight entries, each table vector can be written to its own entry, and a later request can show that an earlier entry survived writes to other entries. An 8-bit size field is the narrowest that holds the 129-byte worst case, so the all-direct, all-32-bit vector checks the upper bound with no headroom to hide a wrap.

// File: rtl/vrs_pkg.sv
// Package: shared types and layout helpers for the vertex record size calculator.
// Assumes 32-bit configuration words and the fixed 21-attribute stream order.
package vrs_pkg;

    localparam int NUM_ATTR      = 21;
    localparam int NUM_MTX       = 9;
    localparam int NUM_TEX       = 8;
    localparam int ATTR_POS      = 9;
    localparam int ATTR_NRM      = 10;
    localparam int ATTR_CLR0     = 11;
    localparam int ATTR_CLR1     = 12;
    localparam int ATTR_TEX0     = 13;
    localparam int MAX_REC_BYTES = 129;

    localparam logic [3:0] GRP_DESC_LO = 4'h5;
    localparam logic [3:0] GRP_DESC_HI = 4'h6;
    localparam logic [3:0] GRP_FMT_A   = 4'h7;
    localparam logic [3:0] GRP_FMT_B   = 4'h8;
    localparam logic [3:0] GRP_FMT_C   = 4'h9;

    typedef enum logic [1:0] {
        KIND_NONE   = 2'd0,
        KIND_DIRECT = 2'd1,
        KIND_IDX8   = 2'd2,
        KIND_IDX16  = 2'd3
    } attr_kind_e;

    typedef enum logic [2:0] {
        CLS_MTX, CLS_POS, CLS_NRM, CLS_CLR, CLS_TEX
    } attr_cls_e;

    typedef struct packed {
        attr_kind_e kind;
        logic       cnt;
        logic [2:0] fmt;
        logic       nrm3;
    } attr_cfg_t;

    // Class of the attribute at a given stream position.
    function automatic attr_cls_e attr_class(input int idx);
        if (idx < NUM_MTX)                          return CLS_MTX;
        else if (idx == ATTR_POS)                   return CLS_POS;
        else if (idx == ATTR_NRM)                   return CLS_NRM;
        else if (idx == ATTR_CLR0 || idx == ATTR_CLR1) return CLS_CLR;
        else                                        return CLS_TEX;
    endfunction

    // Which format word (0=A, 1=B, 2=C) carries texture coordinate k.
    function automatic int tex_word(input int k);
        if (k == 0)      return 0;
        else if (k < 5)  return 1;
        else             return 2;
    endfunction

    // Bit position of texture coordinate k's count bit within its word.
    function automatic int tex_cnt_bit(input int k);
        if (k == 0)      return 21;
        else if (k < 5)  return 9 * (k - 1);
        else             return 5 + 9 * (k - 5);
    endfunction

    // Byte width of one component for a component format code.
    function automatic int comp_bytes(input logic [2:0] fmt);
        if (fmt < 3'd2)       return 1;
        else if (fmt < 3'd4)  return 2;
        else                  return 4;
    endfunction

    // Direct byte width of a colour for a colour format code.
    function automatic int colour_bytes(input logic [2:0] fmt);
        case (fmt)
            3'd0, 3'd3: return 2;
            3'd1, 3'd4: return 3;
            default:    return 4;
        endcase
    endfunction

endpackage

// File: rtl/vrs_cfg_regs.sv
// Module: configuration storage. Holds the two descriptor words and a table of
// NUM_FMT three-word format entries; presents the entry selected by rd_idx
// combinationally. Assumes the group code sits in address bits [7:4] and the
// entry index in the low IDX_W bits.
module vrs_cfg_regs
    import vrs_pkg::*;
#(
    parameter int NUM_FMT = 8,
    parameter int ADDR_W  = 8,
    parameter int IDX_W   = $clog2(NUM_FMT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [31:0]       desc_lo,
    output logic [31:0]       desc_hi,
    output logic [31:0]       fmt_a,
    output logic [31:0]       fmt_b,
    output logic [31:0]       fmt_c
);

    logic [31:0]      tbl_a [NUM_FMT];
    logic [31:0]      tbl_b [NUM_FMT];
    logic [31:0]      tbl_c [NUM_FMT];
    logic [3:0]       grp;
    logic [IDX_W-1:0] wr_idx;

    // Split the address into group code and entry index.
    assign grp    = wr_addr[ADDR_W-1 -: 4];
    assign wr_idx = wr_addr[IDX_W-1:0];

    // Register writes, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            desc_lo <= '0;
            desc_hi <= '0;
            for (int i = 0; i < NUM_FMT; i++) begin
                tbl_a[i] <= '0;
                tbl_b[i] <= '0;
                tbl_c[i] <= '0;
            end
        end else if (wr_en) begin
            case (grp)
                GRP_DESC_LO: desc_lo        <= wr_data;
                GRP_DESC_HI: desc_hi        <= wr_data;
                GRP_FMT_A:   tbl_a[wr_idx]  <= wr_data;
                GRP_FMT_B:   tbl_b[wr_idx]  <= wr_data;
                GRP_FMT_C:   tbl_c[wr_idx]  <= wr_data;
                default: ;
            endcase
        end
    end

    // Read port for the requested format entry.
    assign fmt_a = tbl_a[rd_idx];
    assign fmt_b = tbl_b[rd_idx];
    assign fmt_c = tbl_c[rd_idx];

endmodule

// File: rtl/vrs_attr_decode.sv
// Module: field extraction. Turns descriptor and format words into one
// kind/count/format record per attribute in stream order. Purely combinational.
module vrs_attr_decode
    import vrs_pkg::*;
(
    input  logic [31:0] desc_lo,
    input  logic [31:0] desc_hi,
    input  logic [31:0] fmt_a,
    input  logic [31:0] fmt_b,
    input  logic [31:0] fmt_c,
    output attr_cfg_t   attr_cfg [NUM_ATTR]
);

    // Matrix-index attributes: one presence bit each.
    for (genvar m = 0; m < NUM_MTX; m++) begin : g_mtx
        assign attr_cfg[m] = '{kind: desc_lo[m] ? KIND_DIRECT : KIND_NONE,
                               cnt: 1'b0, fmt: 3'd0, nrm3: 1'b0};
    end

    // Position, normal and both colours come from word A.
    assign attr_cfg[ATTR_POS]  = '{kind: attr_kind_e'(desc_lo[10:9]),
                                  cnt: fmt_a[0], fmt: fmt_a[3:1], nrm3: 1'b0};
    assign attr_cfg[ATTR_NRM]  = '{kind: attr_kind_e'(desc_lo[12:11]),
                                  cnt: fmt_a[9], fmt: fmt_a[12:10], nrm3: fmt_a[31]};
    assign attr_cfg[ATTR_CLR0] = '{kind: attr_kind_e'(desc_lo[14:13]),
                                  cnt: fmt_a[13], fmt: fmt_a[16:14], nrm3: 1'b0};
    assign attr_cfg[ATTR_CLR1] = '{kind: attr_kind_e'(desc_lo[16:15]),
                                  cnt: fmt_a[17], fmt: fmt_a[20:18], nrm3: 1'b0};

    // Texture coordinates: type from the high descriptor, fields spread over words A to C.
    for (genvar k = 0; k < NUM_TEX; k++) begin : g_tex
        localparam int WSEL = tex_word(k);
        localparam int CB   = tex_cnt_bit(k);
        logic [31:0] src;
        if (WSEL == 0)      begin : g_a assign src = fmt_a; end
        else if (WSEL == 1) begin : g_b assign src = fmt_b; end
        else                begin : g_c assign src = fmt_c; end
        assign attr_cfg[ATTR_TEX0+k] = '{kind: attr_kind_e'(desc_hi[2*k +: 2]),
                                         cnt: src[CB], fmt: src[CB+1 +: 3], nrm3: 1'b0};
    end

endmodule

// File: rtl/vrs_attr_sizer.sv
// Module: byte size of one attribute. The class parameter picks the direct
// size rule; indexed sizes depend only on index width and, for the normal,
// the three-index mode. Purely combinational.
module vrs_attr_sizer
    import vrs_pkg::*;
#(
    parameter attr_cls_e CLS    = CLS_MTX,
    parameter int        SIZE_W = 8
) (
    input  attr_cfg_t         cfg,
    output logic [SIZE_W-1:0] bytes
);

    int n_idx;
    int direct;
    int total;

    // Number of indices an indexed attribute carries.
    always_comb begin
        n_idx = (CLS == CLS_NRM && cfg.cnt && cfg.nrm3) ? 3 : 1;
    end

    // Size when the data is inline.
    always_comb begin
        case (CLS)
            CLS_MTX: direct = 1;
            CLS_POS: direct = (cfg.cnt ? 3 : 2) * comp_bytes(cfg.fmt);
            CLS_NRM: direct = (cfg.cnt ? 9 : 3) * comp_bytes(cfg.fmt);
            CLS_CLR: direct = colour_bytes(cfg.fmt);
            default: direct = (cfg.cnt ? 2 : 1) * comp_bytes(cfg.fmt);
        endcase
    end

    // Select by attribute kind.
    always_comb begin
        case (cfg.kind)
            KIND_NONE:   total = 0;
            KIND_DIRECT: total = direct;
            KIND_IDX8:   total = n_idx;
            default:     total = 2 * n_idx;
        endcase
    end

    assign bytes = SIZE_W'(total);

endmodule

// File: rtl/vrs_record_size.sv
// Module: top of the vertex record size calculator. Loads configuration
// through a write port; on a request, sizes every attribute of the selected
// format, forms running offsets and registers size and offsets.
// Assumes SIZE_W is wide enough for the 129-byte worst case.
module vrs_record_size
    import vrs_pkg::*;
#(
    parameter int NUM_FMT = 8,
    parameter int ADDR_W  = 8,
    parameter int SIZE_W  = 8,
    parameter int IDX_W   = $clog2(NUM_FMT)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cfg_wr_en,
    input  logic [ADDR_W-1:0]          cfg_wr_addr,
    input  logic [31:0]                cfg_wr_data,
    input  logic                       req_valid,
    input  logic [IDX_W-1:0]           req_fmt,
    output logic                       rsp_valid,
    output logic [SIZE_W-1:0]          rsp_size,
    output logic [NUM_ATTR*SIZE_W-1:0] rsp_offsets
);

    logic [31:0]                desc_lo, desc_hi, fmt_a, fmt_b, fmt_c;
    attr_cfg_t                  attr_cfg [NUM_ATTR];
    logic [SIZE_W-1:0]          attr_bytes [NUM_ATTR];
    logic [NUM_ATTR*SIZE_W-1:0] ofs_next;
    logic [SIZE_W-1:0]          size_next;

    vrs_cfg_regs #(.NUM_FMT(NUM_FMT), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr_en),
        .wr_addr (cfg_wr_addr),
        .wr_data (cfg_wr_data),
        .rd_idx  (req_fmt),
        .desc_lo (desc_lo),
        .desc_hi (desc_hi),
        .fmt_a   (fmt_a),
        .fmt_b   (fmt_b),
        .fmt_c   (fmt_c)
    );

    vrs_attr_decode u_decode (
        .desc_lo  (desc_lo),
        .desc_hi  (desc_hi),
        .fmt_a    (fmt_a),
        .fmt_b    (fmt_b),
        .fmt_c    (fmt_c),
        .attr_cfg (attr_cfg)
    );

    for (genvar i = 0; i < NUM_ATTR; i++) begin : g_size
        vrs_attr_sizer #(.CLS(attr_class(i)), .SIZE_W(SIZE_W)) u_sizer (
            .cfg   (attr_cfg[i]),
            .bytes (attr_bytes[i])
        );
    end

    // Running sum in stream order: each offset is the sum of the sizes before it.
    always_comb begin
        logic [SIZE_W-1:0] acc;
        acc = '0;
        for (int i = 0; i < NUM_ATTR; i++) begin
            ofs_next[i*SIZE_W +: SIZE_W] = acc;
            acc = acc + attr_bytes[i];
        end
        size_next = acc;
    end

    // Output register, loaded only on a request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid   <= 1'b0;
            rsp_size    <= '0;
            rsp_offsets <= '0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                rsp_size    <= size_next;
                rsp_offsets <= ofs_next;
            end
        end
    end

endmodule

// File: rtl/vrs_record_size_chk.sv
// Module: assertion checker bound to the top module. Checks the response
// timing, reset clearing, offset ordering and size bound.
module vrs_record_size_chk
    import vrs_pkg::*;
#(
    parameter int SIZE_W = 8
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       req_valid,
    input logic                       rsp_valid,
    input logic [SIZE_W-1:0]          rsp_size,
    input logic [NUM_ATTR*SIZE_W-1:0] rsp_offsets
);

    logic in_rst_q;

    // Remember whether the previous edge saw reset.
    always_ff @(posedge clk) in_rst_q <= !rst_n;

    // Width must cover the largest record.
    initial begin
        AST_SIZE_WIDTH: assert ((1 << SIZE_W) > MAX_REC_BYTES); // R11
    end

    // Outputs cleared after a reset edge, checked mid-cycle.
    always @(negedge clk) begin
        if (in_rst_q) begin
            AST_RESET_CLEAR: assert (!rsp_valid && rsp_size == '0 && rsp_offsets == '0); // R1
        end
    end

    AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid); // R2

    AST_NO_RSP_WITHOUT_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid); // R2

    AST_RESULT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> ($stable(rsp_size) && $stable(rsp_offsets))); // R2

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_size <= SIZE_W'(MAX_REC_BYTES)); // R11

    AST_SIZE_COVERS_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_size >= rsp_offsets[(NUM_ATTR-1)*SIZE_W +: SIZE_W]); // R10

    for (genvar k = 0; k < NUM_ATTR - 1; k++) begin : g_order
        AST_OFS_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
            rsp_offsets[(k+1)*SIZE_W +: SIZE_W] >= rsp_offsets[k*SIZE_W +: SIZE_W]); // R10
    end

endmodule

bind vrs_record_size vrs_record_size_chk #(.SIZE_W(SIZE_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .rsp_valid   (rsp_valid),
    .rsp_size    (rsp_size),
    .rsp_offsets (rsp_offsets)
);

// File: tb/vrs_record_size_tb.sv
module vrs_record_size_tb;

    localparam int NATTR = 21;
    localparam int NVEC  = 12;

    typedef struct packed {
        logic [31:0] lo;
        logic [31:0] hi;
        logic [31:0] wa;
        logic [31:0] wb;
        logic [31:0] wc;
        logic [2:0]  fmt;
        logic [7:0]  size;
        logic [4:0]  probe;
        logic [7:0]  pofs;
    } vec_t;

    // lo, hi, A, B, C, entry, size, probed attribute, its offset
    localparam vec_t VECS [NVEC] = '{
        '{32'h0,        32'h0,    32'h0,        32'h0,        32'h0,       3'd0,  8'd0,  5'd20, 8'd0},  // R10 empty
        '{32'h1FF,      32'h0,    32'h0,        32'h0,        32'h0,       3'd1,  8'd9,  5'd9,  8'd9},  // R3
        '{32'h201,      32'h0,    32'h9,        32'h0,        32'h0,       3'd2,  8'd13, 5'd9,  8'd1},  // R5 pos xyz f32
        '{32'hE00,      32'h0,    32'hE00,      32'h0,        32'h0,       3'd3,  8'd20, 5'd10, 8'd2},  // R4 R5
        '{32'h1000,     32'h0,    32'h80000200, 32'h0,        32'h0,       3'd4,  8'd3,  5'd11, 8'd3},  // R7 three idx
        '{32'h1800,     32'h0,    32'h200,      32'h0,        32'h0,       3'd5,  8'd2,  5'd11, 8'd2},  // R7 one idx
        '{32'hA000,     32'h0,    32'h146000,   32'h0,        32'h0,       3'd6,  8'd7,  5'd12, 8'd3},  // R6
        '{32'hA000,     32'h0,    32'h800C0000, 32'h0,        32'h0,       3'd7,  8'd4,  5'd12, 8'd2},  // R6
        '{32'h0,        32'h5555, 32'hA00000,   32'h18181200, 32'h2820020, 3'd0,  8'd27, 5'd20, 8'd23}, // R8
        '{32'h0,        32'hC002, 32'h0,        32'h0,        32'h0,       3'd1,  8'd3,  5'd20, 8'd1},  // R4 tex idx
        '{32'hABFF,     32'h5555, 32'h1289209,  32'h48241209, 32'h4824120, 3'd6,  8'd129,5'd13, 8'd65}, // R11
        '{32'h200,      32'h0,    32'hE,        32'h0,        32'h0,       3'd3,  8'd8,  5'd10, 8'd8}   // R5 code 7
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cfg_wr_en = 1'b0;
    logic [7:0]   cfg_wr_addr = '0;
    logic [31:0]  cfg_wr_data = '0;
    logic         req_valid = 1'b0;
    logic [2:0]   req_fmt = '0;
    logic         rsp_valid;
    logic [7:0]   rsp_size;
    logic [NATTR*8-1:0] rsp_offsets;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    vrs_record_size u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_wr_en   (cfg_wr_en),
        .cfg_wr_addr (cfg_wr_addr),
        .cfg_wr_data (cfg_wr_data),
        .req_valid   (req_valid),
        .req_fmt     (req_fmt),
        .rsp_valid   (rsp_valid),
        .rsp_size    (rsp_size),
        .rsp_offsets (rsp_offsets)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] addr, input logic [31:0] data);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_wr_addr = addr; cfg_wr_data = data;
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    // Request at one edge; results are sampled at the following negedge.
    task automatic request(input logic [2:0] fmt);
        @(negedge clk);
        req_valid = 1'b1; req_fmt = fmt;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    function automatic int ofs(input int idx);
        return int'(rsp_offsets[idx*8 +: 8]);
    endfunction

    // Watchdog: a hung run is a failure.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual %0d expected below %0d", cycles, 20000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs cleared under reset
        check("R1 rsp_valid", int'(rsp_valid), 0);
        check("R1 rsp_size", int'(rsp_size), 0);
        check("R1 offsets", int'(rsp_offsets == '0), 1);
        rst_n = 1'b1;
        // R1: empty table and descriptors give size 0 right after reset
        request(3'd5);
        check("R1 size after reset", int'(rsp_size), 0);

        // Vector table walk
        for (int v = 0; v < NVEC; v++) begin
            wr(8'h50, VECS[v].lo);
            wr(8'h60, VECS[v].hi);
            wr({4'h7, 1'b0, VECS[v].fmt}, VECS[v].wa);
            wr({4'h8, 1'b0, VECS[v].fmt}, VECS[v].wb);
            wr({4'h9, 1'b0, VECS[v].fmt}, VECS[v].wc);
            request(VECS[v].fmt);
            check($sformatf("R10 size vec %0d", v), int'(rsp_size), int'(VECS[v].size));
            check($sformatf("R10 offset vec %0d", v), ofs(int'(VECS[v].probe)), int'(VECS[v].pofs));
            check($sformatf("R2 valid vec %0d", v), int'(rsp_valid), 1);
        end

        // R9: writes to unused groups are ignored (lo=0x200, entry 3 = pos xy code 7)
        wr(8'h30, 32'hFFFF_FFFF);
        wr(8'hA3, 32'hFFFF_FFFF);
        wr(8'hB3, 32'hFFFF_FFFF);
        request(3'd3);
        check("R9 ignored groups", int'(rsp_size), 8);
        // R9: entry 6 kept its own words (pos xyz f32 -> 12)
        request(3'd6);
        check("R9 entry kept", int'(rsp_size), 12);
        check("R10 pos offset entry 6", ofs(9), 0);
        check("R10 nrm offset entry 6", ofs(10), 12);

        // R2: no request -> valid low, result held even across a config write
        @(negedge clk);
        check("R2 valid low", int'(rsp_valid), 0);
        wr(8'h50, 32'h0);
        check("R2 size held", int'(rsp_size), 12);
        check("R2 offset held", ofs(10), 12);

        // R10: all absent gives zero
        request(3'd6);
        check("R10 all absent", int'(rsp_size), 0);

        // R7: nine normals, three-index bit set but direct type -> 9 * 1 byte
        wr(8'h50, 32'h800);
        wr(8'h74, 32'h8000_0200);
        request(3'd4);
        check("R7 direct ignores three-index", int'(rsp_size), 9);

        // R1: reset mid-run clears outputs
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 mid-run size", int'(rsp_size), 0);
        rst_n = 1'b1;
        request(3'd4);
        check("R1 table cleared", int'(rsp_size), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule